// File: doc/BRIEF.md
# Parallel Sampling-ADC Host Controller

This block sits between an on-chip requester and an external 10-bit parallel
sampling converter that has a four-way analog input selector. The requester
presents a channel number and a strobe style over a valid/ready handshake. The
controller drives the converter's active-low enable, sample, and read strobes,
and its two channel-select lines. It waits for the converter's active-low
done signal, takes the 10-bit word from the data bus, and returns the word
with its channel number as a one-cycle response.

The controller supports two strobe styles. In the split style, the sample
strobe is held low for a programmed window. Its rising edge starts the
conversion, and a separate read strobe fetches the word after the done signal
falls. In the joined style, the sample and read strobes fall in the same cycle
and stay low through the conversion. Before the done signal falls, the bus
still carries the previous result, so the controller ignores it.

Every interval is a parameter in clock cycles: select setup, sample width,
read access, inter-conversion gap, and done timeout. The done input comes
through a two-flop synchronizer. If the done signal never arrives, an error
pulse is raised in place of a response and the controller returns to idle.

Top module: `adc_host_ctrl`

## Requirements
- R1: After reset, `adc_cs_n`, `adc_sh_n` and `adc_rd_n` are high, `req_ready` is high and `rsp_valid` and `rsp_err` are low.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low while `adc_cs_n` is low, and each accepted request causes exactly one falling edge of `adc_sh_n`.
- R3: `adc_sel` carries the requested channel as binary (00 selects input 0, 01 input 1, 10 input 2, 11 input 3). It is driven with `adc_cs_n` low for exactly SETUP_CYC cycles before `adc_sh_n` falls, and it does not change while `adc_cs_n` stays low.
- R4: `adc_sh_n` and `adc_rd_n` are low only while `adc_cs_n` is low.
- R5: Split style (`req_mode`=0): `adc_sh_n` stays low for exactly SAMPLE_CYC cycles with `adc_rd_n` high. `adc_rd_n` falls only after the done input has gone low.
- R6: Joined style (`req_mode`=1): `adc_sh_n` and `adc_rd_n` fall in the same cycle and rise in the same cycle.
- R7: The word is captured ACCESS_CYC cycles after the synchronized done input is seen low, so `rsp_valid` rises exactly 3+ACCESS_CYC clock edges after the edge that drove the done input low. Bus data from the previous conversion is never returned.
- R8: `rsp_valid` is a one-cycle pulse that carries the captured word on `rsp_data` and the request's channel on `rsp_chan`.
- R9: If the done input stays high for TIMEOUT_CYC cycles of waiting, `rsp_err` pulses for one cycle without `rsp_valid`, all strobes go high, and the controller accepts the next request normally.
- R10: Between two transactions, `adc_cs_n` stays high for at least GAP_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, ready to take a request |
| req_chan | input | 2 | Requested input channel |
| req_mode | input | 1 | 0 split strobes, 1 joined strobes |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_data | output | 10 | Converted word |
| rsp_chan | output | 2 | Channel tag of the word |
| rsp_err | output | 1 | One-cycle timeout pulse |
| adc_cs_n | output | 1 | Converter enable, active low |
| adc_sh_n | output | 1 | Sample/hold strobe, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_sel | output | 2 | Channel select lines |
| adc_int_n | input | 1 | Conversion done, active low, asynchronous |
| adc_db | input | 10 | Converter data bus |

## Verification
A response is due exactly 3+ACCESS_CYC edges after the converter model drives
done low. The bench records that edge number and compares it against the edge
number at which `rsp_valid` is sampled. Strobe widths are counted in whole
cycles at the falling clock edge: the cycles from enable to sample, the sample
low time, and the enable-high gap. Each width is compared with SETUP_CYC,
SAMPLE_CYC and GAP_CYC at the edge where it ends. Responses are matched in
order against a queue that the request driver fills, so a capture that is too
early (the stale word) or a wrong channel shows up as a data mismatch.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SAMPLE,
    ST_CONV,
    ST_READ,
    ST_GAP
  } ctl_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_sync_chain.sv
module adc_sync_chain #(
  parameter int STAGES   = 2,
  parameter bit RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst)
          chain[i] <= RST_VAL;
        else if (i == 0)
          chain[i] <= d_async;
        else
          chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
  import adc_host_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int CH_W        = 2,
  parameter int SETUP_CYC   = 4,
  parameter int SAMPLE_CYC  = 13,
  parameter int ACCESS_CYC  = 4,
  parameter int GAP_CYC     = 3,
  parameter int TIMEOUT_CYC = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CH_W-1:0]   req_chan,
  input  logic              req_mode,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [CH_W-1:0]   rsp_chan,
  output logic              rsp_err,
  output logic              adc_cs_n,
  output logic              adc_sh_n,
  output logic              adc_rd_n,
  output logic [CH_W-1:0]   adc_sel,
  input  logic              adc_int_n,
  input  logic [DATA_W-1:0] adc_db
);
  localparam int MAX_CYC = imax(imax(imax(SETUP_CYC, SAMPLE_CYC),
                                     imax(ACCESS_CYC, GAP_CYC)), TIMEOUT_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] LD_SETUP   = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_SAMPLE  = CNT_W'(SAMPLE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_ACCESS  = CNT_W'(ACCESS_CYC - 1);
  localparam logic [CNT_W-1:0] LD_GAP     = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TIMEOUT = CNT_W'(TIMEOUT_CYC - 1);

  ctl_state_t       st, nxt;
  logic             mode_q;
  logic [CH_W-1:0]  chan_q;
  logic             int_s;
  logic             t_load, t_done;
  logic [CNT_W-1:0] t_val;
  logic             capture, timeout;

  adc_sync_chain #(.STAGES(2), .RST_VAL(1'b1)) u_int_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (adc_int_n),
    .q_sync  (int_s)
  );

  adc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_done)
  );

  always_comb begin
    nxt     = st;
    t_load  = 1'b0;
    t_val   = '0;
    capture = 1'b0;
    timeout = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (req_valid && req_ready) begin
          nxt = ST_SETUP; t_load = 1'b1; t_val = LD_SETUP;
        end
      end
      ST_SETUP: begin
        if (t_done) begin
          nxt = ST_SAMPLE; t_load = 1'b1;
          t_val = mode_q ? LD_TIMEOUT : LD_SAMPLE;
        end
      end
      ST_SAMPLE: begin
        if (mode_q) begin
          if (!int_s) begin
            nxt = ST_READ; t_load = 1'b1; t_val = LD_ACCESS;
          end else if (t_done) begin
            nxt = ST_GAP; t_load = 1'b1; t_val = LD_GAP; timeout = 1'b1;
          end
        end else if (t_done) begin
          nxt = ST_CONV; t_load = 1'b1; t_val = LD_TIMEOUT;
        end
      end
      ST_CONV: begin
        if (!int_s) begin
          nxt = ST_READ; t_load = 1'b1; t_val = LD_ACCESS;
        end else if (t_done) begin
          nxt = ST_GAP; t_load = 1'b1; t_val = LD_GAP; timeout = 1'b1;
        end
      end
      ST_READ: begin
        if (t_done) begin
          nxt = ST_GAP; t_load = 1'b1; t_val = LD_GAP; capture = 1'b1;
        end
      end
      ST_GAP: begin
        if (t_done) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      mode_q    <= 1'b0;
      chan_q    <= '0;
      req_ready <= 1'b1;
      adc_cs_n  <= 1'b1;
      adc_sh_n  <= 1'b1;
      adc_rd_n  <= 1'b1;
      adc_sel   <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
      rsp_chan  <= '0;
    end else begin
      st        <= nxt;
      req_ready <= (nxt == ST_IDLE);
      adc_cs_n  <= !(nxt == ST_SETUP || nxt == ST_SAMPLE ||
                     nxt == ST_CONV  || nxt == ST_READ);
      adc_sh_n  <= !(nxt == ST_SAMPLE || (nxt == ST_READ && mode_q));
      adc_rd_n  <= !(nxt == ST_READ || (nxt == ST_SAMPLE && mode_q));
      rsp_valid <= capture;
      rsp_err   <= timeout;
      if (st == ST_IDLE && req_valid && req_ready) begin
        mode_q  <= req_mode;
        chan_q  <= req_chan;
        adc_sel <= req_chan;
      end
      if (capture) begin
        rsp_data <= adc_db;
        rsp_chan <= chan_q;
      end
    end
  end
endmodule

// File: rtl/adc_host_ctrl_chk.sv
module adc_host_ctrl_chk #(
  parameter int CH_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            adc_cs_n,
  input logic            adc_sh_n,
  input logic            adc_rd_n,
  input logic [CH_W-1:0] adc_sel,
  input logic            rsp_valid,
  input logic            rsp_err,
  input logic            int_s
);
  assert_strobe_needs_cs_R4: assert property (@(posedge clk) disable iff (rst)
    (!adc_sh_n || !adc_rd_n) |-> !adc_cs_n);

  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (rst)
    !adc_cs_n |-> !req_ready);

  assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_sel_steady_R3: assert property (@(posedge clk) disable iff (rst)
    (!adc_cs_n && $past(!adc_cs_n)) |-> $stable(adc_sel));

  assert_joined_fall_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(adc_sh_n) && !adc_rd_n) |-> $fell(adc_rd_n));

  assert_read_after_done_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(adc_rd_n) && adc_sh_n) |-> $past(!int_s));

  assert_rsp_single_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_err_excl_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> !rsp_valid);
endmodule

bind adc_host_ctrl adc_host_ctrl_chk #(.CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .adc_cs_n  (adc_cs_n),
  .adc_sh_n  (adc_sh_n),
  .adc_rd_n  (adc_rd_n),
  .adc_sel   (adc_sel),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .int_s     (int_s)
);

// File: tb/adc_host_ctrl_tb_top.sv
module adc_host_ctrl_tb_top;
  localparam int SETUP  = 4;
  localparam int SAMPLE = 13;
  localparam int ACCESS = 4;
  localparam int GAP    = 3;
  localparam int TMO    = 200;
  localparam int M1_DLY = 30;
  localparam int M2_DLY = 43;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_chan = 2'd0;
  logic req_mode = 1'b0;
  logic rsp_valid, rsp_err;
  logic [9:0] rsp_data;
  logic [1:0] rsp_chan;
  logic cs_n, sh_n, rd_n;
  logic [1:0] sel;
  logic int_n;
  logic [9:0] db;

  int total = 0, bad = 0;
  int cyc = 0, int_cyc = 0;
  int drv_n = 0, m_n = 0;
  bit no_int = 1'b0;
  logic [1:0] cur_ch = 2'd0;
  logic cur_mode = 1'b0;
  logic [12:0] exp_q[$];

  always #10 clk = ~clk;

  adc_host_ctrl #(.SETUP_CYC(SETUP), .SAMPLE_CYC(SAMPLE), .ACCESS_CYC(ACCESS),
                  .GAP_CYC(GAP), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_mode(req_mode), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_chan(rsp_chan), .rsp_err(rsp_err),
    .adc_cs_n(cs_n), .adc_sh_n(sh_n), .adc_rd_n(rd_n), .adc_sel(sel),
    .adc_int_n(int_n), .adc_db(db));

  function automatic logic [9:0] code_of(input logic [1:0] ch, input int n);
    return 10'((n * 37 + int'(ch) * 200 + 5) % 1024);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model
  logic sh_d = 1'b1, rd_d = 1'b1;
  int cnt = 0;
  logic [9:0] m_code = '0, result = '0;
  assign db = (!cs_n && !rd_n) ? result : 10'd0;

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    sh_d <= sh_n;
    rd_d <= rd_n;
    if (rst) begin
      int_n <= 1'b1;
      cnt   <= 0;
    end else begin
      if (sh_d && !sh_n && !cs_n) begin
        m_code <= code_of(sel, m_n);
        m_n    <= m_n + 1;
        if (!rd_n) cnt <= M2_DLY;
      end else if (!sh_d && sh_n && rd_d && !cs_n) begin
        cnt <= M1_DLY;
      end else if (cnt != 0) begin
        cnt <= cnt - 1;
        if (cnt == 1 && !no_int) begin
          int_n   <= 1'b0;
          result  <= m_code;
          int_cyc <= cyc + 1;
        end
      end
      if (!rd_d && rd_n) int_n <= 1'b1;
    end
  end

  // protocol monitor and scoreboard
  logic p_cs = 1'b1, p_sh = 1'b1, p_rd = 1'b1;
  int setup_n = 0, low_n = 0, gap_n = 100;
  always @(negedge clk) begin
    if (!rst) begin
      if (!cs_n && sh_n && p_sh) setup_n++;
      if (cs_n) gap_n++;
      if (p_cs && !cs_n) begin
        chk(gap_n >= GAP, "R10 enable-high gap", gap_n, GAP);
        setup_n = 1;
      end
      if (p_sh && !sh_n) begin
        chk(setup_n == SETUP, "R3 select setup cycles", setup_n, SETUP);
        chk(sel == cur_ch, "R3 select encoding", sel, cur_ch);
        low_n = 0;
        if (cur_mode) chk(!rd_n && p_rd, "R6 joined fall", rd_n, 0);
        else          chk(rd_n, "R5 read high while sampling", rd_n, 1);
      end
      if (!sh_n) low_n++;
      if (!p_sh && sh_n) begin
        if (!cur_mode) chk(low_n == SAMPLE, "R5 sample width", low_n, SAMPLE);
        else           chk(rd_n && !p_rd, "R6 joined rise", rd_n, 1);
      end
      if (p_rd && !rd_n && !cur_mode)
        chk(!int_n, "R5 read after done", int_n, 0);
      if (!cs_n) chk(!req_ready, "R2 not ready while busy", req_ready, 0);
      if ((!sh_n || !rd_n) && cs_n) chk(0, "R4 strobe without enable", cs_n, 0);
      if (cs_n && !p_cs) gap_n = 0;
      if (rsp_valid || rsp_err) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected response", 1, 0);
        else begin
          logic [12:0] e;
          e = exp_q.pop_front();
          chk(rsp_err == e[12], "R9 error flag", rsp_err, e[12]);
          chk(!(rsp_valid && rsp_err), "R9 error without data", rsp_valid, 0);
          if (rsp_valid) begin
            chk(rsp_data == e[9:0], "R7 data word", rsp_data, e[9:0]);
            chk(rsp_chan == e[11:10], "R8 channel tag", rsp_chan, e[11:10]);
            chk(cyc - int_cyc == 3 + ACCESS, "R7 response latency",
                cyc - int_cyc, 3 + ACCESS);
          end
        end
      end
      if (p_rd == 1'b0 && rsp_valid) ; // sample alignment only
    end
    p_cs = cs_n; p_sh = sh_n; p_rd = rd_n;
  end

  task automatic send(input logic [1:0] ch, input logic md, input bit tmo);
    @(negedge clk);
    req_valid = 1'b1; req_chan = ch; req_mode = md;
    while (!req_ready) @(negedge clk);
    cur_ch = ch; cur_mode = md; no_int = tmo;
    exp_q.push_back({tmo, ch, tmo ? 10'd0 : code_of(ch, drv_n)});
    drv_n++;
    @(negedge clk);
    req_valid = 1'b0;
    req_chan  = ~ch;
    if (tmo) begin
      while (!req_ready) @(negedge clk);
      no_int = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n && sh_n && rd_n, "R1 strobes high in reset", {cs_n, sh_n, rd_n}, 7);
    chk(req_ready && !rsp_valid && !rsp_err, "R1 ready/idle in reset",
        {req_ready, rsp_valid, rsp_err}, 4);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n && sh_n && rd_n && req_ready, "R1 idle after reset",
        {cs_n, sh_n, rd_n, req_ready}, 15);
    for (int c = 0; c < 4; c++) send(2'(c), 1'b0, 1'b0);
    for (int c = 0; c < 4; c++) send(2'(3 - c), 1'b1, 1'b0);
    send(2'd2, 1'b0, 1'b1);
    send(2'd1, 1'b0, 1'b0);
    send(2'd3, 1'b1, 1'b1);
    send(2'd0, 1'b1, 1'b0);
    for (int c = 0; c < 4; c++) send(2'(c), c[0], 1'b0);
    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(m_n == drv_n, "R2 one conversion per request", m_n, drv_n);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule